// File: doc/BRIEF.md
# Programmed-I/O Serial Terminal Adapter

This block sits between a processor's programmed-I/O bus and a serial receiver/transmitter pair. The processor puts a 6-bit device number on the bus and issues one of three command pulses, named here the test, clear and transfer pulses. The block recognizes two device numbers. Octal 03 is the receive side and octal 04 is the transmit side. The block answers in the same cycles with a skip request, an accumulator-clear request, an OR-into-accumulator request and a 12-bit input word.

The receive side reflects the receiver's data-ready line as its flag. For a transfer, it enables the receiver's character onto the input word. The transmit side keeps its own flag, which software clears with the clear pulse. The flag is set again only when the transmitter's buffer-empty line rises. Either flag raises the interrupt request.

Everything runs on the system clock. Command pulses are edge-detected, so each one-shot side effect happens exactly once per pulse, however long the pulse is held.

Top module: `pio_term_if`

## Requirements
- R1: A pulse while the device number is neither 03 nor 04 has no effect on any output. The transmit flag also keeps its value.
- R2: During a test pulse (`cmd_test`) at 03, `skip` equals `rx_ready` as sampled in the pulse's first cycle. It keeps that value for the rest of the pulse, even if `rx_ready` changes.
- R3: During a test pulse at 04, `skip` equals the transmit flag as sampled in the pulse's first cycle. It keeps that value for the whole pulse.
- R4: During a clear pulse (`cmd_clear`) at 03, `acc_clr` is high for every cycle of the pulse. `rx_ready_rst` is high only in the pulse's first cycle.
- R5: During a transfer pulse (`cmd_xfer`) at 03, `or_acc`, `rx_rd_en` and `in_word_oe` are high for the whole pulse. `in_word` is `{4'b0000, rx_char}` in that time. At all other times `in_word_oe` is low and `in_word` is zero.
- R6: The clear pulse at 04 clears the transmit flag from the next cycle on, and it does not strobe `tx_load`. If a buffer-empty rising edge arrives in the same cycle, the set wins.
- R7: The transfer pulse at 04 raises `tx_load` for exactly its first cycle. `tx_char` always carries `acc_out`.
- R8: The transmit flag goes high one cycle after a cycle in which `tx_empty` is high and was low in the previous cycle. It stays low after a clear while `tx_empty` stays high.
- R9: `irq` equals `rx_ready` OR the transmit flag at every cycle.
- R10: While and after reset, the transmit flag and both captured skip values are zero. The strobes and the requests are low while no pulse is active. A `tx_empty` that is already high at reset does not set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_num | input | 6 | Device number from the bus |
| cmd_test | input | 1 | Test (skip query) pulse |
| cmd_clear | input | 1 | Clear pulse |
| cmd_xfer | input | 1 | Transfer pulse |
| acc_out | input | 8 | Low accumulator bits from the processor |
| skip | output | 1 | Skip request |
| acc_clr | output | 1 | Accumulator-clear request |
| or_acc | output | 1 | OR-input-into-accumulator request |
| in_word | output | 12 | Input word to the processor |
| in_word_oe | output | 1 | Input word is being driven |
| rx_ready | input | 1 | Receiver has a character |
| rx_char | input | 8 | Received character |
| rx_ready_rst | output | 1 | One-cycle reset of receiver data-ready |
| rx_rd_en | output | 1 | Receiver read enable |
| tx_empty | input | 1 | Transmitter buffer empty |
| tx_char | output | 8 | Character to the transmitter |
| tx_load | output | 1 | One-cycle transmitter load strobe |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle these properties:
- The one-shot strobes last a single cycle.
- The skip value stays stable within a test pulse.
- The transmit flag rises only after buffer-empty was high and falls only after an addressed clear.
- The input word is zero while it is not driven, and no request comes from an unrecognized device number.

Other behaviours can only be shown by the bench's scenarios, which compare against a behavioural model on every clock:
- The skip value is sampled at the pulse start, not later (skip held high after `rx_ready` drops, held low after it rises).
- A buffer-empty edge that coincides with a clear sets the flag.
- A `tx_empty` held high at reset never sets the flag.

// File: rtl/pio_term_pkg.sv
package pio_term_pkg;
    localparam int unsigned DEV_W  = 6;
    localparam int unsigned CHAR_W = 8;
    localparam int unsigned WORD_W = 12;

    localparam logic [DEV_W-1:0] DEV_RX = 6'o03;
    localparam logic [DEV_W-1:0] DEV_TX = 6'o04;

    typedef struct packed {
        logic xfer;
        logic clear;
        logic test;
    } pio_cmd_t;

    function automatic logic [WORD_W-1:0] widen_char(input logic [CHAR_W-1:0] c);
        return {{(WORD_W-CHAR_W){1'b0}}, c};
    endfunction
endpackage

// File: rtl/pio_edge.sv
module pio_edge #(
    parameter int unsigned W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] level,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= RST_VAL;
        else     prev_q <= level;
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign rise[i] = level[i] & ~prev_q[i];
    end
endmodule

// File: rtl/pio_rx_side.sv
module pio_rx_side
    import pio_term_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              test,
    input  logic              clear,
    input  logic              xfer,
    input  logic              test_first,
    input  logic              clear_first,
    input  logic              rx_ready,
    input  logic [CHAR_W-1:0] rx_char,
    output logic              skip,
    output logic              acc_clr,
    output logic              ready_rst,
    output logic              rd_en,
    output logic              or_acc,
    output logic [WORD_W-1:0] in_word,
    output logic              in_word_oe
);
    logic cap_q;
    logic test_hit;

    assign test_hit = sel & test;

    always_ff @(posedge clk) begin
        if (rst)                          cap_q <= 1'b0;
        else if (test_hit && test_first)  cap_q <= rx_ready;
    end

    always_comb begin
        skip = 1'b0;
        if (test_hit) skip = test_first ? rx_ready : cap_q;
    end

    assign acc_clr    = sel & clear;
    assign ready_rst  = sel & clear & clear_first;
    assign rd_en      = sel & xfer;
    assign or_acc     = sel & xfer;
    assign in_word_oe = sel & xfer;
    assign in_word    = (sel & xfer) ? widen_char(rx_char) : '0;

    AST_SKIP_HELD: assert property (@(posedge clk) disable iff (rst)
        (test_hit && $past(test_hit) && !test_first) |-> $stable(skip)) else $error("skip moved"); // R2
    AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        ready_rst |=> !ready_rst) else $error("ready reset too long"); // R4
    AST_WORD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_word_oe |-> (in_word == '0)) else $error("word not idle"); // R5
    AST_WORD_UPPER: assert property (@(posedge clk) disable iff (rst)
        in_word_oe |-> (in_word[WORD_W-1:CHAR_W] == '0)) else $error("upper bits set"); // R5
endmodule

// File: rtl/pio_tx_side.sv
module pio_tx_side
    import pio_term_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              test,
    input  logic              test_first,
    input  logic              clear_first,
    input  logic              xfer_first,
    input  logic              tx_empty,
    input  logic              empty_rise,
    input  logic [CHAR_W-1:0] acc_out,
    output logic              skip,
    output logic              tx_load,
    output logic [CHAR_W-1:0] tx_char,
    output logic              flag
);
    logic flag_q;
    logic cap_q;
    logic clr_hit;

    assign clr_hit = sel & clear_first;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            cap_q  <= 1'b0;
        end else begin
            if (empty_rise)   flag_q <= 1'b1;
            else if (clr_hit) flag_q <= 1'b0;
            if (sel && test && test_first) cap_q <= flag_q;
        end
    end

    always_comb begin
        skip = 1'b0;
        if (sel && test) skip = test_first ? flag_q : cap_q;
    end

    assign flag    = flag_q;
    assign tx_load = sel & xfer_first;
    assign tx_char = acc_out;

    AST_FLAG_SET_SRC: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> $past(tx_empty)) else $error("flag set w/o empty"); // R8
    AST_FLAG_CLR_SRC: assert property (@(posedge clk) disable iff (rst)
        $fell(flag_q) |-> $past(clr_hit)) else $error("flag cleared w/o command"); // R6
    AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        tx_load |=> !tx_load) else $error("load too long"); // R7
    AST_SKIP_TX_HELD: assert property (@(posedge clk) disable iff (rst)
        (sel && test && $past(sel && test) && !test_first) |-> $stable(skip)) else $error("tx skip moved"); // R3
endmodule

// File: rtl/pio_term_if.sv
module pio_term_if
    import pio_term_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DEV_W-1:0]  dev_num,
    input  logic              cmd_test,
    input  logic              cmd_clear,
    input  logic              cmd_xfer,
    input  logic [CHAR_W-1:0] acc_out,
    output logic              skip,
    output logic              acc_clr,
    output logic              or_acc,
    output logic [WORD_W-1:0] in_word,
    output logic              in_word_oe,
    input  logic              rx_ready,
    input  logic [CHAR_W-1:0] rx_char,
    output logic              rx_ready_rst,
    output logic              rx_rd_en,
    input  logic              tx_empty,
    output logic [CHAR_W-1:0] tx_char,
    output logic              tx_load,
    output logic              irq
);
    pio_cmd_t cmd_lvl, cmd_first;
    logic     empty_rise;
    logic     sel_rx, sel_tx;
    logic     rx_skip, tx_skip, tx_flag;

    assign cmd_lvl = '{xfer: cmd_xfer, clear: cmd_clear, test: cmd_test};
    assign sel_rx  = (dev_num == DEV_RX);
    assign sel_tx  = (dev_num == DEV_TX);

    pio_edge #(.W(3), .RST_VAL(3'b000)) u_cmd_edge (
        .clk(clk), .rst(rst), .level(cmd_lvl), .rise(cmd_first)
    );

    pio_edge #(.W(1), .RST_VAL(1'b1)) u_empty_edge (
        .clk(clk), .rst(rst), .level(tx_empty), .rise(empty_rise)
    );

    pio_rx_side u_rx (
        .clk(clk), .rst(rst), .sel(sel_rx),
        .test(cmd_test), .clear(cmd_clear), .xfer(cmd_xfer),
        .test_first(cmd_first.test), .clear_first(cmd_first.clear),
        .rx_ready(rx_ready), .rx_char(rx_char),
        .skip(rx_skip), .acc_clr(acc_clr), .ready_rst(rx_ready_rst),
        .rd_en(rx_rd_en), .or_acc(or_acc),
        .in_word(in_word), .in_word_oe(in_word_oe)
    );

    pio_tx_side u_tx (
        .clk(clk), .rst(rst), .sel(sel_tx),
        .test(cmd_test), .test_first(cmd_first.test),
        .clear_first(cmd_first.clear), .xfer_first(cmd_first.xfer),
        .tx_empty(tx_empty), .empty_rise(empty_rise), .acc_out(acc_out),
        .skip(tx_skip), .tx_load(tx_load), .tx_char(tx_char), .flag(tx_flag)
    );

    assign skip = rx_skip | tx_skip;
    assign irq  = rx_ready | tx_flag;

    AST_NO_FOREIGN_REPLY: assert property (@(posedge clk) disable iff (rst)
        (!sel_rx && !sel_tx) |-> !(skip || acc_clr || or_acc || tx_load || rx_ready_rst || rx_rd_en))
        else $error("reply to foreign device"); // R1
    AST_IRQ_FROM_RX: assert property (@(posedge clk) disable iff (rst)
        rx_ready |-> irq) else $error("irq missing"); // R9
endmodule

// File: tb/test_pio_term_if.sv
`timescale 1ns/1ps
module test_pio_term_if;
    logic        clk = 1'b0;
    logic        rst;
    logic [5:0]  dev_num;
    logic        cmd_test, cmd_clear, cmd_xfer;
    logic [7:0]  acc_out, rx_char;
    logic        rx_ready, tx_empty;
    logic        skip, acc_clr, or_acc, in_word_oe, rx_ready_rst, rx_rd_en, tx_load, irq;
    logic [11:0] in_word;
    logic [7:0]  tx_char;

    // staged stimulus, applied at the falling edge
    logic [5:0] s_dev = 0;
    logic s_rst = 1, s_t = 0, s_c = 0, s_x = 0, s_rdy = 0, s_emp = 1;
    logic [7:0] s_acc = 0, s_rch = 0;

    int total = 0, bad = 0;

    // behavioural reference state
    bit m_flag, m_cap_rx, m_cap_tx, m_prev_t, m_prev_c, m_prev_x, m_prev_e;

    always #2.5 clk = ~clk;

    pio_term_if i_pio_term_if (
        .clk(clk), .rst(rst), .dev_num(dev_num), .cmd_test(cmd_test),
        .cmd_clear(cmd_clear), .cmd_xfer(cmd_xfer), .acc_out(acc_out),
        .skip(skip), .acc_clr(acc_clr), .or_acc(or_acc), .in_word(in_word),
        .in_word_oe(in_word_oe), .rx_ready(rx_ready), .rx_char(rx_char),
        .rx_ready_rst(rx_ready_rst), .rx_rd_en(rx_rd_en), .tx_empty(tx_empty),
        .tx_char(tx_char), .tx_load(tx_load), .irq(irq)
    );

    task automatic chk(string req, string what, logic [11:0] act, logic [11:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic tick();
        bit a_rx, a_tx, e_skip;
        string rq;
        @(negedge clk);
        rst = s_rst; dev_num = s_dev; cmd_test = s_t; cmd_clear = s_c; cmd_xfer = s_x;
        acc_out = s_acc; rx_ready = s_rdy; rx_char = s_rch; tx_empty = s_emp;
        #1;
        a_rx = (dev_num == 6'd3);
        a_tx = (dev_num == 6'd4);
        e_skip = 0;
        if (!rst && cmd_test && a_rx) e_skip = m_prev_t ? m_cap_rx : rx_ready;
        if (!rst && cmd_test && a_tx) e_skip = m_prev_t ? m_cap_tx : m_flag;
        rq = rst ? "R10" : ((!a_rx && !a_tx) ? "R1" : "");
        chk(rq == "" ? (a_rx ? "R2" : "R3") : rq, "skip", {11'b0, skip}, {11'b0, e_skip});
        chk(rq == "" ? "R4" : rq, "acc_clr", {11'b0, acc_clr}, {11'b0, cmd_clear & a_rx});
        chk(rq == "" ? "R4" : rq, "rx_ready_rst", {11'b0, rx_ready_rst},
            {11'b0, cmd_clear & a_rx & ~m_prev_c});
        chk(rq == "" ? "R5" : rq, "or_acc", {11'b0, or_acc}, {11'b0, cmd_xfer & a_rx});
        chk(rq == "" ? "R5" : rq, "rx_rd_en", {11'b0, rx_rd_en}, {11'b0, cmd_xfer & a_rx});
        chk(rq == "" ? "R5" : rq, "in_word_oe", {11'b0, in_word_oe}, {11'b0, cmd_xfer & a_rx});
        chk(rq == "" ? "R5" : rq, "in_word", in_word, (cmd_xfer & a_rx) ? {4'h0, rx_char} : 12'h000);
        chk(rq == "" ? "R7" : rq, "tx_load", {11'b0, tx_load}, {11'b0, cmd_xfer & a_tx & ~m_prev_x});
        chk("R7", "tx_char", {4'h0, tx_char}, {4'h0, acc_out});
        chk(rst ? "R10" : "R9", "irq", {11'b0, irq}, {11'b0, rx_ready | m_flag});
        @(posedge clk);
        if (rst) begin
            m_flag = 0; m_cap_rx = 0; m_cap_tx = 0;
            m_prev_t = 0; m_prev_c = 0; m_prev_x = 0; m_prev_e = 1;
        end else begin
            if (cmd_test && !m_prev_t && a_rx) m_cap_rx = rx_ready;
            if (cmd_test && !m_prev_t && a_tx) m_cap_tx = m_flag;
            if (tx_empty && !m_prev_e)                  m_flag = 1;   // R8
            else if (cmd_clear && !m_prev_c && a_tx)    m_flag = 0;   // R6
            m_prev_t = cmd_test; m_prev_c = cmd_clear; m_prev_x = cmd_xfer; m_prev_e = tx_empty;
        end
    endtask

    task automatic pulse(logic [5:0] dev, int which, int len);
        s_dev = dev;
        s_t = (which == 1); s_c = (which == 2); s_x = (which == 4);
        for (int i = 0; i < len; i++) tick();
        s_t = 0; s_c = 0; s_x = 0;
        tick();
    endtask

    initial begin
        #100000;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R10: reset with tx_empty high, then idle: flag must stay clear
        s_rst = 1; repeat (3) tick();
        s_rst = 0; repeat (3) tick();
        pulse(6'd4, 1, 3);                 // R3: skip 0

        // R8: empty falls then rises -> flag, irq
        s_emp = 0; tick(); s_emp = 1; repeat (2) tick();
        pulse(6'd4, 1, 4);                 // R3: skip 1 held
        // R6: clear, empty stays high, flag stays low
        pulse(6'd4, 2, 3);
        repeat (3) tick();
        pulse(6'd4, 1, 2);
        // R7: transfer, long pulse, single load
        s_acc = 8'h5A; pulse(6'd4, 4, 4);
        s_acc = 8'hA7; s_emp = 0; repeat (2) tick();
        s_emp = 1; tick();
        // R6: coincident clear and empty rise -> set wins
        s_emp = 0; repeat (2) tick();
        s_dev = 6'd4; s_c = 1; s_emp = 1; tick(); tick();
        s_c = 0; tick();
        pulse(6'd4, 1, 2);

        // R2: ready drops mid-pulse, skip held high
        s_rdy = 1; tick();
        s_dev = 6'd3; s_t = 1; tick(); s_rdy = 0; repeat (3) tick(); s_t = 0; tick();
        // R2: ready rises mid-pulse, skip held low
        s_t = 1; tick(); s_rdy = 1; repeat (3) tick(); s_t = 0; tick();
        // R4: clear at receive side
        pulse(6'd3, 2, 4);
        // R5: transfer at receive side
        s_rch = 8'hC3; pulse(6'd3, 4, 3);
        s_rch = 8'h3C; pulse(6'd3, 4, 1);

        // R1: foreign device numbers with every pulse; flag unchanged (seen on irq/skip)
        s_rdy = 0;
        for (int k = 0; k < 3; k++) begin
            pulse(6'd5, 1, 2); pulse(6'd5, 2, 2); pulse(6'd5, 4, 2);
            pulse(6'o43, 1, 1); pulse(6'o43, 2, 1); pulse(6'd0, 4, 1);
        end
        pulse(6'd4, 1, 2);
        pulse(6'd4, 2, 1);
        pulse(6'd0, 2, 2);
        pulse(6'd4, 1, 2);

        // R10: reset mid-run clears flag
        s_emp = 0; tick(); s_emp = 1; tick(); tick();
        s_rst = 1; repeat (2) tick(); s_rst = 0; repeat (2) tick();
        pulse(6'd4, 1, 2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule